// File: doc/BRIEF.md
# Fault Capture Bank with Attention Routing

This block collects error reports from one hardware unit into a 64-bit bank of sticky capture bits. A one-cycle pulse on any error input line sets the matching capture bit, which stays set until software clears it. A mask register hides chosen bits. Two parallel action registers give every bit a two-bit code, and the code sends each unmasked captured bit to one of four attention classes: checkstop, recoverable, host attention or unit checkstop. Each class drives one registered summary output.

Software reaches the bank through a small register bus. The bus has a write strobe, a three-bit word offset and combinational read data. Besides the plain read/write words, two alias offsets give atomic updates. A write to the clear alias ANDs the data into the capture register. A write to the mask-set alias ORs the data into the mask. Because of these aliases, no read-modify-write sequence is needed to clear a fault or to hide a bit.

Top module: `fault_capture_bank`

## Requirements
- R1: After reset the capture register reads 0, the mask reads all ones, both action registers read 0 and all four attention outputs are low.
- R2: A high level on err_in[i] during one clock edge sets capture bit i, and the bit stays set over later cycles until a bus write clears it.
- R3: A bus write to offset 0 loads the capture register with the write data, and a read of offset 0 returns the current capture register.
- R4: A bus write to offset 1 ANDs the write data into the capture register, so zero bits clear. If an error pulse and a clear hit the same bit in the same cycle, the bit ends up set.
- R5: Offset 3 is the mask register, read and write. A write to offset 5 ORs the write data into the mask and leaves the other mask bits as they were.
- R6: Offset 6 is action register 0 and offset 7 is action register 1, both read and write.
- R7: A capture bit is active only when it is 1 and its mask bit is 0. A masked captured bit raises no attention output.
- R8: For an active bit, the code {action0, action1} selects the output: 00 = attn_checkstop, 01 = attn_recoverable, 10 = attn_host, 11 = attn_unit_cs. Each output is the OR of the active bits in its class, and it changes one clock edge after the register state that produces it.
- R9: A read of offset 1 returns the capture register and a read of offset 5 returns the mask. Offsets 2 and 4 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_in | input | 64 | Error pulses from the monitored unit, one line per capture bit |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 3 | Bus word offset within the bank |
| bus_wdata | input | 64 | Bus write data |
| bus_rdata | output | 64 | Bus read data for bus_addr (combinational) |
| attn_checkstop | output | 1 | Checkstop attention summary |
| attn_recoverable | output | 1 | Recoverable attention summary |
| attn_host | output | 1 | Host attention summary |
| attn_unit_cs | output | 1 | Unit checkstop summary |

## Verification
The assertions check four properties on every cycle. Capture bits only rise when no write is in progress. An error pulse always shows up in the capture register, even when a clear comes in the same cycle. The AND alias and the OR alias apply exactly their operation. A fully masked bank raises no attention. Only the bench's scenarios can show the class mapping. It sweeps every bit position with action codes computed from the bit index and checks that the expected single output rises after one register stage and falls after a clear. The bench scenarios also cover the reset values, the alias read-back and the offsets that have no register.

// File: rtl/fcb_pkg.sv
package fcb_pkg;
    localparam int OFFS_W = 3;

    // Word offsets within the bank; software depends on these positions.
    localparam logic [OFFS_W-1:0] OFFS_CAP     = 3'd0;
    localparam logic [OFFS_W-1:0] OFFS_CAP_AND = 3'd1;
    localparam logic [OFFS_W-1:0] OFFS_MSK     = 3'd3;
    localparam logic [OFFS_W-1:0] OFFS_MSK_OR  = 3'd5;
    localparam logic [OFFS_W-1:0] OFFS_ACT0    = 3'd6;
    localparam logic [OFFS_W-1:0] OFFS_ACT1    = 3'd7;

    // Attention class index equals the {action0, action1} code.
    typedef enum logic [1:0] {
        CLS_CHECKSTOP   = 2'b00,
        CLS_RECOVERABLE = 2'b01,
        CLS_HOST        = 2'b10,
        CLS_UNIT_CS     = 2'b11
    } attn_class_e;

    localparam int NUM_CLASSES = 4;
endpackage

// File: rtl/fcb_regs.sv
module fcb_regs
    import fcb_pkg::*;
#(
    parameter int W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      err_in,
    input  logic              bus_we,
    input  logic [OFFS_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      cap_q,
    output logic [W-1:0]      msk_q,
    output logic [W-1:0]      act0_q,
    output logic [W-1:0]      act1_q
);
    typedef struct packed {
        logic [W-1:0] cap;
        logic [W-1:0] msk;
        logic [W-1:0] act0;
        logic [W-1:0] act1;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bus_we) begin
            unique case (bus_addr)
                OFFS_CAP:     st_d.cap  = bus_wdata;
                OFFS_CAP_AND: st_d.cap  = st_q.cap & bus_wdata;
                OFFS_MSK:     st_d.msk  = bus_wdata;
                OFFS_MSK_OR:  st_d.msk  = st_q.msk | bus_wdata;
                OFFS_ACT0:    st_d.act0 = bus_wdata;
                OFFS_ACT1:    st_d.act1 = bus_wdata;
                default:      st_d = st_q;
            endcase
        end
        // An arriving error always wins over a clear in the same cycle.
        st_d.cap = st_d.cap | err_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cap  <= '0;
            st_q.msk  <= '1;
            st_q.act0 <= '0;
            st_q.act1 <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_q  = st_q.cap;
    assign msk_q  = st_q.msk;
    assign act0_q = st_q.act0;
    assign act1_q = st_q.act1;
endmodule

// File: rtl/fcb_route.sv
module fcb_route
    import fcb_pkg::*;
#(
    parameter int W = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [W-1:0]           cap,
    input  logic [W-1:0]           msk,
    input  logic [W-1:0]           act0,
    input  logic [W-1:0]           act1,
    output logic [NUM_CLASSES-1:0] attn_q
);
    logic [W-1:0]           live;
    logic [NUM_CLASSES-1:0] hit;

    assign live = cap & ~msk;

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
        localparam logic [1:0] CODE = 2'(c);
        logic [W-1:0] sel0, sel1;
        assign sel0   = CODE[1] ? act0 : ~act0;
        assign sel1   = CODE[0] ? act1 : ~act1;
        assign hit[c] = |(live & sel0 & sel1);
    end

    typedef struct packed {
        logic [NUM_CLASSES-1:0] attn;
    } route_t;

    route_t rt_d, rt_q;

    always_comb begin
        rt_d      = rt_q;
        rt_d.attn = hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rt_q <= '0;
        else        rt_q <= rt_d;
    end

    assign attn_q = rt_q.attn;
endmodule

// File: rtl/fcb_rdmux.sv
module fcb_rdmux
    import fcb_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [OFFS_W-1:0] addr,
    input  logic [W-1:0]      cap,
    input  logic [W-1:0]      msk,
    input  logic [W-1:0]      act0,
    input  logic [W-1:0]      act1,
    output logic [W-1:0]      rdata
);
    always_comb begin
        unique case (addr)
            OFFS_CAP, OFFS_CAP_AND: rdata = cap;
            OFFS_MSK, OFFS_MSK_OR:  rdata = msk;
            OFFS_ACT0:              rdata = act0;
            OFFS_ACT1:              rdata = act1;
            default:                rdata = '0;
        endcase
    end
endmodule

// File: rtl/fault_capture_bank.sv
module fault_capture_bank
    import fcb_pkg::*;
#(
    parameter int W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      err_in,
    input  logic              bus_we,
    input  logic [OFFS_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic              attn_checkstop,
    output logic              attn_recoverable,
    output logic              attn_host,
    output logic              attn_unit_cs
);
    logic [W-1:0]           cap_vec, msk_vec, act0_vec, act1_vec;
    logic [NUM_CLASSES-1:0] attn_vec;

    fcb_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .err_in   (err_in),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .cap_q    (cap_vec),
        .msk_q    (msk_vec),
        .act0_q   (act0_vec),
        .act1_q   (act1_vec)
    );

    fcb_route #(.W(W)) u_route (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (cap_vec),
        .msk   (msk_vec),
        .act0  (act0_vec),
        .act1  (act1_vec),
        .attn_q(attn_vec)
    );

    fcb_rdmux #(.W(W)) u_rdmux (
        .addr (bus_addr),
        .cap  (cap_vec),
        .msk  (msk_vec),
        .act0 (act0_vec),
        .act1 (act1_vec),
        .rdata(bus_rdata)
    );

    assign attn_checkstop   = attn_vec[CLS_CHECKSTOP];
    assign attn_recoverable = attn_vec[CLS_RECOVERABLE];
    assign attn_host        = attn_vec[CLS_HOST];
    assign attn_unit_cs     = attn_vec[CLS_UNIT_CS];
endmodule

// File: rtl/fcb_checker.sv
module fcb_checker
    import fcb_pkg::*;
#(
    parameter int W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [W-1:0]      err_in,
    input logic              bus_we,
    input logic [OFFS_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      cap_vec,
    input logic [W-1:0]      msk_vec,
    input logic              attn_checkstop,
    input logic              attn_recoverable,
    input logic              attn_host,
    input logic              attn_unit_cs
);
    // R2: with no bus write, captured bits never drop
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_we) |-> ((cap_vec & $past(cap_vec)) == $past(cap_vec)));

    // R4: an error pulse is always captured, even against a clear
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err_in) != '0) |-> ((cap_vec & $past(err_in)) == $past(err_in)));

    // R4: the AND alias applies exactly an AND when nothing arrives
    p_and_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_we) && $past(bus_addr) == OFFS_CAP_AND && $past(err_in) == '0)
        |-> (cap_vec == ($past(cap_vec) & $past(bus_wdata))));

    // R5: the OR alias keeps every written one in the mask
    p_mask_or_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_we) && $past(bus_addr) == OFFS_MSK_OR)
        |-> ((msk_vec & $past(bus_wdata)) == $past(bus_wdata)));

    // R7: a fully masked bank raises nothing
    p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(msk_vec) == '1)
        |-> !(attn_checkstop || attn_recoverable || attn_host || attn_unit_cs));
endmodule

bind fault_capture_bank fcb_checker #(.W(W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .err_in          (err_in),
    .bus_we          (bus_we),
    .bus_addr        (bus_addr),
    .bus_wdata       (bus_wdata),
    .cap_vec         (cap_vec),
    .msk_vec         (msk_vec),
    .attn_checkstop  (attn_checkstop),
    .attn_recoverable(attn_recoverable),
    .attn_host       (attn_host),
    .attn_unit_cs    (attn_unit_cs)
);

// File: tb/fault_capture_bank_tb.sv
module fault_capture_bank_tb;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] err_in = '0;
    logic         bus_we = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         a_cs, a_rec, a_host, a_ucs;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    fault_capture_bank #(.W(W)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .err_in          (err_in),
        .bus_we          (bus_we),
        .bus_addr        (bus_addr),
        .bus_wdata       (bus_wdata),
        .bus_rdata       (bus_rdata),
        .attn_checkstop  (a_cs),
        .attn_recoverable(a_rec),
        .attn_host       (a_host),
        .attn_unit_cs    (a_ucs)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] attn_now();
        return {{(W-4){1'b0}}, a_ucs, a_host, a_rec, a_cs};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [W-1:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd(3'd0, v); check("R1 cap", v, '0);
        rd(3'd3, v); check("R1 mask", v, '1);
        rd(3'd6, v); check("R1 act0", v, '0);
        rd(3'd7, v); check("R1 act1", v, '0);
        check("R1 attn", attn_now(), '0);

        // R7: masked bank ignores errors at the outputs
        @(negedge clk); err_in = 64'h1; @(negedge clk); err_in = '0;
        @(negedge clk); check("R7 masked attn", attn_now(), '0);
        wr(3'd0, '0);

        // R3: plain load and read back
        wr(3'd0, 64'hDEAD_BEEF_0123_4567);
        rd(3'd0, v); check("R3 cap rw", v, 64'hDEAD_BEEF_0123_4567);
        // R9: alias reads
        rd(3'd1, v); check("R9 cap alias read", v, 64'hDEAD_BEEF_0123_4567);
        // R4: AND clear
        wr(3'd1, 64'hFFFF_0000_FFFF_0000);
        rd(3'd0, v); check("R4 and clear", v, 64'hDEAD_0000_0123_0000);
        // R4: set wins over same-cycle clear
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 3'd1; bus_wdata = '0; err_in = 64'h20;
        @(negedge clk);
        bus_we = 1'b0; err_in = '0;
        rd(3'd0, v); check("R4 set wins", v, 64'h20);
        wr(3'd0, '0);

        // R5: mask rw and OR alias
        wr(3'd3, 64'h00F0);
        wr(3'd5, 64'h0F00);
        rd(3'd3, v); check("R5 mask or", v, 64'h0FF0);
        rd(3'd5, v); check("R9 mask alias read", v, 64'h0FF0);

        // R6: action registers
        wr(3'd6, 64'hA5A5_0000_1111_2222);
        wr(3'd7, 64'h5A5A_FFFF_3333_4444);
        rd(3'd6, v); check("R6 act0", v, 64'hA5A5_0000_1111_2222);
        rd(3'd7, v); check("R6 act1", v, 64'h5A5A_FFFF_3333_4444);

        // R9: unused offsets read zero and writes change nothing
        wr(3'd2, '1);
        wr(3'd4, '1);
        rd(3'd2, v); check("R9 off2 zero", v, '0);
        rd(3'd4, v); check("R9 off4 zero", v, '0);
        rd(3'd0, v); check("R9 cap kept", v, '0);
        rd(3'd3, v); check("R9 mask kept", v, 64'h0FF0);
        rd(3'd6, v); check("R9 act0 kept", v, 64'hA5A5_0000_1111_2222);

        // R8 sweep: codes computed from the bit index
        begin
            logic [W-1:0] p0, p1;
            p0 = '0; p1 = '0;
            for (int i = 0; i < W; i++) begin
                p0[i] = i[0] ^ i[3];
                p1[i] = i[1];
            end
            wr(3'd6, p0);
            wr(3'd7, p1);
            wr(3'd3, '0);
            for (int i = 0; i < W; i++) begin
                logic [W-1:0] one;
                logic [W-1:0] exp;
                one = '0; one[i] = 1'b1;
                exp = '0; exp[{p0[i], p1[i]}] = 1'b1;
                @(negedge clk); err_in = one;
                @(negedge clk); err_in = '0;
                // R8: latency of one register after capture
                check("R8 not yet", attn_now(), '0);
                // R2: bit captured and held
                #1 bus_addr = 3'd0;
                #1 check("R2 captured", bus_rdata, one);
                @(negedge clk);
                check("R8 class", attn_now(), exp);
                @(negedge clk);
                check("R2 held", attn_now(), exp);
                wr(3'd1, ~one);
                @(negedge clk);
                check("R8 drops after clear", attn_now(), '0);
                // R7: masked bit raises nothing
                wr(3'd5, one);
                @(negedge clk); err_in = one;
                @(negedge clk); err_in = '0;
                @(negedge clk);
                check("R7 masked bit", attn_now(), '0);
                wr(3'd0, '0);
                wr(3'd3, '0);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule